// File: doc/BRIEF.md
# Remote DMA Packet Buffer Controller

This block moves data between a host-side data stream and a local packet buffer RAM, one byte or one 16-bit word per accepted beat. The host programs it through a small byte-wide register file: a 16-bit start address and a 16-bit byte count, each written as a low byte and a high byte, a width select, and two page registers that bound a circular receive region. A write to the command register starts a remote read (buffer to host) or a remote write (host to buffer), or aborts the one in progress.

While a transfer runs, the current buffer address and the remaining count can be read back. When the count reaches zero the block raises a completion flag in an interrupt status register. Software clears that flag by writing a one to its bit. Remote reads that step onto the ring end page continue from the ring start page. Remote writes run linearly.

Host data travels on two valid/ready streams. The inbound stream (`in_*`) carries remote-write data. A beat moves when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` is low only while a remote read is running. The outbound stream (`out_*`) offers remote-read data. `out_valid` stays high and `out_data` stays stable until `out_ready` is seen, so the host can hold back the stream for any number of cycles.

Top module: `rdma_ctrl`

## Requirements
- R1: After reset the command register (offset 0) reads 0x21, the status register (offset 7) reads 0x80, the current address (offsets 1/2) and count (offsets 3/4) read 0, `out_valid` is low, `out_data` is 0 and `in_ready` is high.
- R2: Offsets 1 (low) and 2 (high) hold the start address. Offsets 3 (low) and 4 (high) load the byte count. While a transfer runs and after it ends, reads of offsets 1/2 return the current address and reads of offsets 3/4 return the remaining count.
- R3: A command write with bit 1 (start) set and bits 5:3 equal to 001 starts a remote read at the start address. The same write with bits 5:3 equal to 010 starts a remote write. Bit 0 is stop, bit 2 is transmit and bits 7:6 are the page select; these bits read back as written.
- R4: When offset 8 bit 0 is 0 (byte mode), each beat moves one byte. Inbound data is taken from bits 7:0, and outbound data carries the byte in bits 7:0 with bits 15:8 zero. The address steps by 1 and the count drops by 1.
- R5: When offset 8 bit 0 is 1 (word mode), each beat moves 16 bits, little-endian: bits 7:0 go to the current address and bits 15:8 to the next one. The address steps by 2 and the count drops by 2, saturating at zero when the count is odd.
- R6: When a beat brings the count to zero, the transfer ends and status bit 6 (done) is set on the same clock edge. A start with a count of zero sets the done bit at once and offers no data.
- R7: Writing 1 to a status bit clears it, writing 0 to it leaves it unchanged, and 0xFF clears both bit 7 (reset flag) and bit 6. A done event in the same cycle as the clear wins.
- R8: On a remote read, an address that steps onto page stop (offset 6, times 256) becomes page start (offset 5, times 256). A remote write steps linearly across page stop.
- R9: A command write with bit 5 set ends any transfer at once without setting the done bit. The remaining count and the address are kept.
- R10: With no write transfer running, an inbound beat is accepted and dropped, and the address and count do not change. With no read transfer running, `out_valid` is low and `out_data` is 0. `in_ready` is low while a read runs.
- R11: Bits 5:3 of the command register read 001 during a read, 010 during a write, and 100 when no transfer is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| in_valid | input | 1 | Inbound beat offered |
| in_ready | output | 1 | Inbound beat can be taken |
| in_data | input | 16 | Inbound beat data |
| out_valid | output | 1 | Outbound beat offered |
| out_ready | input | 1 | Host takes outbound beat |
| out_data | output | 16 | Outbound beat data |

## Verification
The bench targets the ring wrap on reads, which a design with a wrong boundary compare would let run into the page past the ring end and return the bytes written there. An odd count in word mode checks that the count saturates: a design without saturation would wrap the count to 0xFFFF and never raise the done bit. The bench aborts a transfer partway through. A design that treated the abort as a normal end would set the done bit, and one that kept its state would keep consuming beats. Idle inbound beats and a zero-count start are also covered, because a design that misses the guard on either would corrupt the address or offer a bogus outbound beat.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam int ADDR_W = 16;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_CMD     = 4'd0,
    RA_ADDR_LO = 4'd1,
    RA_ADDR_HI = 4'd2,
    RA_CNT_LO  = 4'd3,
    RA_CNT_HI  = 4'd4,
    RA_PG_FIRST= 4'd5,
    RA_PG_LAST = 4'd6,
    RA_STATUS  = 4'd7,
    RA_CFG     = 4'd8
  } reg_addr_e;

  localparam logic [2:0] OP_READ  = 3'b001;
  localparam logic [2:0] OP_WRITE = 3'b010;
  localparam logic [2:0] OP_IDLE  = 3'b100;

  localparam int ST_RESET_BIT = 7;
  localparam int ST_DONE_BIT  = 6;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] cur_cnt,
  input  logic              busy,
  input  logic              dir_wr,
  input  logic              done,
  output logic [ADDR_W-1:0] start_addr,
  output logic [7:0]        pg_first,
  output logic [7:0]        pg_last,
  output logic              word_mode,
  output logic              go_rd,
  output logic              go_wr,
  output logic              abort,
  output logic              cnt_we_lo,
  output logic              cnt_we_hi
);
  logic       stp_q, sta_q, txp_q;
  logic [1:0] pg_q;
  logic       rst_flag, done_flag;
  logic [2:0] op_wr;
  logic       cmd_wr, st_wr;

  assign cmd_wr    = reg_we && (reg_addr == RA_CMD);
  assign st_wr     = reg_we && (reg_addr == RA_STATUS);
  assign op_wr     = reg_wdata[5:3];
  assign abort     = cmd_wr && op_wr[2];
  assign go_rd     = cmd_wr && reg_wdata[1] && (op_wr == OP_READ);   // R3
  assign go_wr     = cmd_wr && reg_wdata[1] && (op_wr == OP_WRITE);  // R3
  assign cnt_we_lo = reg_we && (reg_addr == RA_CNT_LO);
  assign cnt_we_hi = reg_we && (reg_addr == RA_CNT_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stp_q      <= 1'b1;
      sta_q      <= 1'b0;
      txp_q      <= 1'b0;
      pg_q       <= 2'b00;
      start_addr <= '0;
      pg_first   <= 8'h00;
      pg_last    <= 8'h00;
      word_mode  <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CMD: begin
          stp_q <= reg_wdata[0];
          sta_q <= reg_wdata[1];
          txp_q <= reg_wdata[2];
          pg_q  <= reg_wdata[7:6];
        end
        RA_ADDR_LO:  start_addr[7:0]  <= reg_wdata;
        RA_ADDR_HI:  start_addr[15:8] <= reg_wdata;
        RA_PG_FIRST: pg_first <= reg_wdata;
        RA_PG_LAST:  pg_last  <= reg_wdata;
        RA_CFG:      word_mode <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // Status flags: write-one-to-clear, a done event in the same cycle wins (R7)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_flag  <= 1'b1;
      done_flag <= 1'b0;
    end else begin
      if (st_wr && reg_wdata[ST_RESET_BIT]) rst_flag <= 1'b0;
      if (st_wr && reg_wdata[ST_DONE_BIT])  done_flag <= 1'b0;
      if (done)                             done_flag <= 1'b1;
    end
  end

  logic [2:0] op_rd;
  assign op_rd = busy ? (dir_wr ? OP_WRITE : OP_READ) : OP_IDLE;  // R11

  always_comb begin
    case (reg_addr)
      RA_CMD:      reg_rdata = {pg_q, op_rd, txp_q, sta_q, stp_q};
      RA_ADDR_LO:  reg_rdata = cur_addr[7:0];
      RA_ADDR_HI:  reg_rdata = cur_addr[15:8];
      RA_CNT_LO:   reg_rdata = cur_cnt[7:0];
      RA_CNT_HI:   reg_rdata = cur_cnt[15:8];
      RA_PG_FIRST: reg_rdata = pg_first;
      RA_PG_LAST:  reg_rdata = pg_last;
      RA_STATUS:   reg_rdata = {rst_flag, done_flag, 6'b0};
      RA_CFG:      reg_rdata = {7'b0, word_mode};
      default:     reg_rdata = 8'h00;
    endcase
  end

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done_flag);  // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[ST_DONE_BIT] && !done) |=> !done_flag);  // R7
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_rd,
  input  logic              go_wr,
  input  logic              abort,
  input  logic              cnt_we_lo,
  input  logic              cnt_we_hi,
  input  logic [7:0]        cnt_wdata,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        pg_first,
  input  logic [7:0]        pg_last,
  input  logic              word_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              busy,
  output logic              dir_wr,
  output logic              done,
  output logic              mem_we,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] cur_cnt
);
  logic [ADDR_W-1:0] step, inc_addr, nxt_addr, ring_lo, ring_hi;
  logic              beat, last, go, wrap_hit;

  assign go       = go_rd || go_wr;
  assign step     = word_mode ? 16'd2 : 16'd1;
  assign ring_lo  = {pg_first, 8'h00};
  assign ring_hi  = {pg_last, 8'h00};
  assign inc_addr = cur_addr + step;
  assign wrap_hit = !dir_wr && (inc_addr == ring_hi);          // R8
  assign nxt_addr = wrap_hit ? ring_lo : inc_addr;
  assign last     = (cur_cnt <= step);                          // R5 saturation

  assign in_ready  = !(busy && !dir_wr);                        // R10
  assign out_valid = busy && !dir_wr && (cur_cnt != '0);
  assign beat      = busy && (cur_cnt != '0) && (dir_wr ? in_valid : out_ready);
  assign mem_we    = beat && dir_wr;
  assign done      = (!abort && go && (cur_cnt == '0)) || (!abort && !go && beat && last);  // R6

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      dir_wr   <= 1'b0;
      cur_addr <= '0;
      cur_cnt  <= '0;
    end else begin
      if (abort) begin
        busy <= 1'b0;                                           // R9
      end else if (go) begin
        busy     <= (cur_cnt != '0);
        dir_wr   <= go_wr;
        cur_addr <= start_addr;
      end else if (beat) begin
        cur_addr <= nxt_addr;
        cur_cnt  <= last ? '0 : cur_cnt - step;
        if (last) busy <= 1'b0;
      end
      if (cnt_we_lo) cur_cnt[7:0]  <= cnt_wdata;
      if (cnt_we_hi) cur_cnt[15:8] <= cnt_wdata;
    end
  end

  AST_BYTE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !word_mode && cur_cnt > 16'd1 && !go && !abort && !cnt_we_lo && !cnt_we_hi)
      |=> cur_cnt == $past(cur_cnt) - 16'd1);  // R4
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && word_mode && cur_cnt > 16'd2 && !go && !abort && !cnt_we_lo && !cnt_we_hi)
      |=> cur_cnt == $past(cur_cnt) - 16'd2);  // R5
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);  // R9
  AST_RING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !dir_wr && !go && !abort && pg_first != pg_last) |=> cur_addr != ring_hi);  // R8
endmodule

// File: rtl/rdma_buf.sv
module rdma_buf #(
  parameter int BUF_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic              word,
  input  logic [BUF_AW-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata
);
  localparam int BANK_AW    = BUF_AW - 1;
  localparam int BANK_DEPTH = 1 << BANK_AW;

  logic [BANK_AW-1:0] idx_lo, idx_hi;
  logic [7:0]         rd_bank [2];

  assign idx_lo = addr[BUF_AW-1:1];
  assign idx_hi = addr[BUF_AW-1:1] + {{(BANK_AW-1){1'b0}}, addr[0]};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0]         mem [BANK_DEPTH];
    logic               takes_lo;
    logic [BANK_AW-1:0] idx;
    logic [7:0]         wd;
    logic               wen;

    assign takes_lo = (addr[0] == b[0]);
    assign idx      = takes_lo ? idx_lo : idx_hi;
    assign wd       = takes_lo ? wdata[7:0] : wdata[15:8];
    assign wen      = we && (takes_lo || word);

    always_ff @(posedge clk) begin
      if (wen) mem[idx] <= wd;
    end
    assign rd_bank[b] = mem[idx];
  end

  assign rdata = addr[0] ? {rd_bank[0], rd_bank[1]} : {rd_bank[1], rd_bank[0]};
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int BUF_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [15:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [15:0] out_data
);
  logic [ADDR_W-1:0] start_addr, cur_addr, cur_cnt;
  logic [7:0]        pg_first, pg_last;
  logic              word_mode, go_rd, go_wr, abort, cnt_we_lo, cnt_we_hi;
  logic              busy, dir_wr, done, mem_we;
  logic [15:0]       buf_rdata, buf_wdata;

  rdma_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .busy(busy), .dir_wr(dir_wr), .done(done),
    .start_addr(start_addr), .pg_first(pg_first), .pg_last(pg_last), .word_mode(word_mode),
    .go_rd(go_rd), .go_wr(go_wr), .abort(abort), .cnt_we_lo(cnt_we_lo), .cnt_we_hi(cnt_we_hi)
  );

  rdma_engine u_engine (
    .clk(clk), .rst_n(rst_n),
    .go_rd(go_rd), .go_wr(go_wr), .abort(abort),
    .cnt_we_lo(cnt_we_lo), .cnt_we_hi(cnt_we_hi), .cnt_wdata(reg_wdata),
    .start_addr(start_addr), .pg_first(pg_first), .pg_last(pg_last), .word_mode(word_mode),
    .in_valid(in_valid), .in_ready(in_ready), .out_ready(out_ready), .out_valid(out_valid),
    .busy(busy), .dir_wr(dir_wr), .done(done), .mem_we(mem_we),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt)
  );

  // Byte mode carries only the low byte in either direction (R4)
  assign buf_wdata = word_mode ? in_data : {8'h00, in_data[7:0]};

  rdma_buf #(.BUF_AW(BUF_AW)) u_buf (
    .clk(clk), .we(mem_we), .word(word_mode),
    .addr(cur_addr[BUF_AW-1:0]), .wdata(buf_wdata), .rdata(buf_rdata)
  );

  always_comb begin
    if (!out_valid)     out_data = 16'h0000;                  // R10
    else if (word_mode) out_data = buf_rdata;                 // R5
    else                out_data = {8'h00, buf_rdata[7:0]};   // R4
  end
endmodule

// File: tb/rdma_ctrl_tb.sv
module rdma_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = 16'h0000;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rdma_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, {24'h0, v}, {24'h0, exp});
  endtask

  task automatic push(input logic [15:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pull_chk(input string req, input logic [15:0] exp);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk({req, " valid"}, {31'h0, out_valid}, 32'h1);
    chk({req, " data"}, {16'h0, out_data}, {16'h0, exp});
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] n, input logic [7:0] cmd);
    wr(4'd1, a[7:0]); wr(4'd2, a[15:8]);
    wr(4'd3, n[7:0]); wr(4'd4, n[15:8]);
    wr(4'd0, cmd);
  endtask

  task automatic t_reset();
    rd_chk("R1 cmd", 4'd0, 8'h21);
    rd_chk("R1 status", 4'd7, 8'h80);
    rd_chk("R1 addr", 4'd1, 8'h00);
    rd_chk("R1 count", 4'd3, 8'h00);
    #1;
    chk("R1 out_valid", {31'h0, out_valid}, 32'h0);
    chk("R1 out_data", {16'h0, out_data}, 32'h0);
    chk("R1 in_ready", {31'h0, in_ready}, 32'h1);
  endtask

  task automatic t_status_w1c();
    wr(4'd7, 8'h40);
    rd_chk("R7 zero bit keeps reset flag", 4'd7, 8'h80);
    wr(4'd7, 8'h80);
    rd_chk("R7 one bit clears reset flag", 4'd7, 8'h00);
  endtask

  task automatic t_byte();
    wr(4'd8, 8'h00);
    setup(16'h0010, 16'd4, 8'h12);                      // R3 write start
    rd_chk("R11 write op field", 4'd0, 8'h12);
    push(16'hFFA0); push(16'hFFA1);
    rd_chk("R2 count mid", 4'd3, 8'h02);
    rd_chk("R4 addr mid", 4'd1, 8'h12);
    push(16'hFFA2); push(16'hFFA3);
    rd_chk("R6 done flag", 4'd7, 8'h40);
    rd_chk("R2 addr low end", 4'd1, 8'h14);
    rd_chk("R2 addr high end", 4'd2, 8'h00);
    rd_chk("R11 idle op field", 4'd0, 8'h22);
    wr(4'd7, 8'hFF);
    rd_chk("R7 0xFF clears", 4'd7, 8'h00);
    wr(4'd3, 8'd4); wr(4'd0, 8'h0A);                    // R3 read start
    rd_chk("R11 read op field", 4'd0, 8'h0A);
    #1 chk("R10 in_ready low in read", {31'h0, in_ready}, 32'h0);
    pull_chk("R4 byte0", 16'h00A0);
    pull_chk("R4 byte1", 16'h00A1);
    pull_chk("R4 byte2", 16'h00A2);
    pull_chk("R4 byte3", 16'h00A3);
    #1;
    chk("R10 out_valid idle", {31'h0, out_valid}, 32'h0);
    chk("R10 out_data idle", {16'h0, out_data}, 32'h0);
    rd_chk("R6 read done", 4'd7, 8'h40);
    wr(4'd7, 8'hFF);
  endtask

  task automatic t_word();
    wr(4'd8, 8'h01);
    setup(16'h0020, 16'd5, 8'h12);
    push(16'h1122); push(16'h3344);
    rd_chk("R5 count minus 4", 4'd3, 8'h01);
    rd_chk("R5 addr plus 4", 4'd1, 8'h24);
    push(16'h5566);
    rd_chk("R5 count saturates", 4'd3, 8'h00);
    rd_chk("R5 done on odd count", 4'd7, 8'h40);
    rd_chk("R5 addr plus 6", 4'd1, 8'h26);
    wr(4'd7, 8'hFF);
    wr(4'd3, 8'd6); wr(4'd0, 8'h0A);
    pull_chk("R5 word0", 16'h1122);
    pull_chk("R5 word1", 16'h3344);
    pull_chk("R5 word2", 16'h5566);
    wr(4'd7, 8'hFF);
    wr(4'd8, 8'h00);
    wr(4'd3, 8'd2); wr(4'd0, 8'h0A);
    pull_chk("R5 little-endian low", 16'h0022);
    pull_chk("R5 little-endian high", 16'h0011);
    wr(4'd7, 8'hFF);
  endtask

  task automatic t_zero_count();
    setup(16'h0010, 16'd0, 8'h0A);
    rd_chk("R6 zero count done", 4'd7, 8'h40);
    rd_chk("R6 zero count idle", 4'd0, 8'h22);
    #1 chk("R6 zero count no data", {31'h0, out_valid}, 32'h0);
    wr(4'd7, 8'hFF);
  endtask

  task automatic t_ring();
    wr(4'd5, 8'h01); wr(4'd6, 8'h02);
    setup(16'h01FE, 16'd4, 8'h12);
    push(16'h0011); push(16'h0022); push(16'h0077); push(16'h0088);
    rd_chk("R8 write linear low", 4'd1, 8'h02);
    rd_chk("R8 write linear high", 4'd2, 8'h02);
    setup(16'h0100, 16'd2, 8'h12);
    push(16'h0055); push(16'h0066);
    wr(4'd7, 8'hFF);
    setup(16'h01FE, 16'd4, 8'h0A);
    pull_chk("R8 before end 0", 16'h0011);
    pull_chk("R8 before end 1", 16'h0022);
    rd_chk("R8 wrapped addr low", 4'd1, 8'h00);
    rd_chk("R8 wrapped addr high", 4'd2, 8'h01);
    pull_chk("R8 after wrap 0", 16'h0055);
    pull_chk("R8 after wrap 1", 16'h0066);
    wr(4'd7, 8'hFF);
  endtask

  task automatic t_abort_idle();
    setup(16'h0040, 16'd10, 8'h12);
    push(16'h0001); push(16'h0002);
    wr(4'd0, 8'h22);
    rd_chk("R9 op field idle", 4'd0, 8'h22);
    rd_chk("R9 no done flag", 4'd7, 8'h00);
    rd_chk("R9 count kept", 4'd3, 8'h08);
    #1 chk("R10 in_ready idle", {31'h0, in_ready}, 32'h1);
    push(16'h0003);
    rd_chk("R10 idle beat count", 4'd3, 8'h08);
    rd_chk("R10 idle beat addr", 4'd1, 8'h42);
    setup(16'h0010, 16'd3, 8'h0A);
    pull_chk("R9 read before abort", 16'h00A0);
    wr(4'd0, 8'h22);
    #1;
    chk("R9 read aborted", {31'h0, out_valid}, 32'h0);
    chk("R10 out_data after abort", {16'h0, out_data}, 32'h0);
    rd_chk("R9 read abort no done", 4'd7, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_status_w1c();
    t_byte();
    t_word();
    t_zero_count();
    t_ring();
    t_abort_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule